// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a 14-bit virtual address to a 20-bit physical address through a table of four segment descriptors. The two most significant address bits choose a descriptor. The remaining twelve bits form an offset inside that segment. Each descriptor holds a valid flag, a 20-bit base and a 12-bit limit. The offset is added to the base, and in the same cycle it is compared against the limit. A request that falls outside its segment, or that uses a segment not marked valid, produces a fault response in place of an address.

The descriptor table is loaded through a configuration write port. A write takes effect only when the privilege input is high. Supervisor software is expected to reload all four descriptors whenever it switches tasks. An attempt to write without privilege leaves the table unchanged and produces a one-cycle privilege-fault pulse. Responses are registered, so a request presented in one cycle is answered in the next.

Top module: `seg_translator`

## Requirements
- R1: While reset is active, and in the first cycle after it, `rsp_valid`, `rsp_fault`, `priv_fault` and `rsp_paddr` are all zero. Reset marks every descriptor invalid.
- R2: The segment index is `req_vaddr[13:12]` and the offset is `req_vaddr[11:0]`.
- R3: Take a request whose descriptor is valid and whose offset is at most the limit. In the next cycle `rsp_valid` is 1, `rsp_fault` is 0 and `rsp_paddr` equals base + offset.
- R4: An offset equal to the limit is legal. An offset greater than the limit gives `rsp_fault`=1 and `rsp_valid`=0 in the next cycle.
- R5: A request to a descriptor whose valid flag is 0 faults, whatever its offset.
- R6: Every cycle with `req_valid`=1 is followed by exactly one of `rsp_valid` or `rsp_fault`. A cycle without a request is followed by neither.
- R7: When `cfg_we`=1 and `cfg_priv`=1, descriptor `cfg_index` takes `cfg_base`, `cfg_limit` and `cfg_valid` at the clock edge. Requests from the following cycle onward use the new values.
- R8: When `cfg_we`=1 and `cfg_priv`=0, the table is left unchanged and `priv_fault` is 1 for exactly the next cycle.
- R9: When a request and a privileged write to the same descriptor fall in one cycle, the request is translated with the descriptor contents from before the write.
- R10: The sum of base and offset wraps modulo 2^20.
- R11: `rsp_paddr` is zero in any cycle where `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address: segment index in the top 2 bits, offset in the low 12 bits |
| rsp_valid | output | 1 | Translation succeeded; `rsp_paddr` holds the result |
| rsp_paddr | output | 20 | Physical address |
| rsp_fault | output | 1 | Translation trapped (limit exceeded or descriptor invalid) |
| cfg_we | input | 1 | Descriptor write request |
| cfg_priv | input | 1 | Privilege qualifier for the write |
| cfg_index | input | 2 | Descriptor to write |
| cfg_base | input | 20 | New base |
| cfg_limit | input | 12 | New limit (highest legal offset) |
| cfg_valid | input | 1 | New valid flag |
| priv_fault | output | 1 | One-cycle pulse after an unprivileged write attempt |

## Verification
A lookup and a privileged reload of the same descriptor can fall in the same cycle. The bench provokes this by driving both together on segment 0 and then repeating the lookup in the next cycle. The first response must carry the old base and the second the new base. The reference table in the scoreboard forms the expectation before it applies the write.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths and descriptor type for the segment translator.
// Assumes the virtual address is exactly segment index bits plus offset bits.
package seg_xlate_pkg;
    parameter int SEG_W   = 2;
    parameter int OFF_W   = 12;
    parameter int PA_W    = 20;
    localparam int VA_W    = SEG_W + OFF_W;
    localparam int NUM_SEG = 1 << SEG_W;

    typedef struct packed {
        logic             valid;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
    } seg_desc_t;
endpackage

// File: rtl/seg_desc_table.sv
// Module: seg_desc_table
// Holds one descriptor per segment and offers a combinational read port.
// A write lands at the clock edge only when it is qualified by privilege.
// Assumes: synchronous active-low reset; a read in the same cycle as a write
// returns the contents from before the write.
module seg_desc_table
    import seg_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic               wr_priv,
    input  logic [SEG_W-1:0]   wr_idx,
    input  seg_desc_t          wr_desc,
    input  logic [SEG_W-1:0]   rd_idx,
    output seg_desc_t          rd_desc
);
    localparam seg_desc_t DESC_CLEAR = '0;

    seg_desc_t [NUM_SEG-1:0] tbl_q;
    logic                    wr_ok;

    // Only privileged writes reach the storage.
    assign wr_ok = wr_req && wr_priv;

    genvar g;
    generate
        for (g = 0; g < NUM_SEG; g++) begin : g_entry
            // Per-entry register: clear on reset, load on a matching privileged write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl_q[g] <= DESC_CLEAR;
                end else if (wr_ok && (wr_idx == SEG_W'(g))) begin
                    tbl_q[g] <= wr_desc;
                end
            end
        end
    endgenerate

    // Read mux selected by the segment index of the current request.
    assign rd_desc = tbl_q[rd_idx];

    // R8: an unprivileged write must leave every descriptor untouched.
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_priv) |=> $stable(tbl_q));

    // R7: a privileged write is visible in the addressed entry afterwards.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_priv) |=> (tbl_q[$past(wr_idx)] == $past(wr_desc)));
endmodule

// File: rtl/seg_add_check.sv
// Module: seg_add_check
// Computes base + offset and the limit comparison side by side, with no
// dependency between them, so that both settle within a single cycle.
// Assumes: the sum wraps at the physical address width.
module seg_add_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t          desc,
    input  logic [OFF_W-1:0]   offset,
    output logic [PA_W-1:0]    paddr,
    output logic               allowed
);
    logic in_limit;

    // Adder path: zero-extend the offset and sum; the carry out is dropped.
    always_comb begin
        paddr = desc.base + {{(PA_W-OFF_W){1'b0}}, offset};
    end

    // Compare path: the offset must not exceed the limit, inclusive.
    always_comb begin
        in_limit = (offset <= desc.limit);
        allowed  = desc.valid && in_limit;
    end
endmodule

// File: rtl/seg_translator.sv
// Module: seg_translator (top)
// Splits the virtual address, looks up the segment descriptor, forms the
// physical address and the legality check in parallel, and registers the
// outcome. Also flags unprivileged descriptor writes with a one-cycle pulse.
// Assumes: synchronous active-low reset; one request per cycle at most.
module seg_translator
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [SEG_W-1:0]  cfg_index,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [OFF_W-1:0]  cfg_limit,
    input  logic              cfg_valid,
    output logic              priv_fault
);
    logic [SEG_W-1:0] seg_idx;
    logic [OFF_W-1:0] seg_off;
    seg_desc_t        cur_desc;
    seg_desc_t        new_desc;
    logic [PA_W-1:0]  sum_pa;
    logic             legal;

    // Address split: segment index on top, offset below.
    assign seg_idx = req_vaddr[VA_W-1:OFF_W];
    assign seg_off = req_vaddr[OFF_W-1:0];

    // Pack the configuration fields into a descriptor.
    always_comb begin
        new_desc.valid = cfg_valid;
        new_desc.base  = cfg_base;
        new_desc.limit = cfg_limit;
    end

    seg_desc_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (cfg_we),
        .wr_priv (cfg_priv),
        .wr_idx  (cfg_index),
        .wr_desc (new_desc),
        .rd_idx  (seg_idx),
        .rd_desc (cur_desc)
    );

    seg_add_check u_addchk (
        .desc    (cur_desc),
        .offset  (seg_off),
        .paddr   (sum_pa),
        .allowed (legal)
    );

    // Response register: result or fault, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid && legal;
            rsp_fault <= req_valid && !legal;
            rsp_paddr <= (req_valid && legal) ? sum_pa : '0;
        end
    end

    // Privilege-violation pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_fault <= 1'b0;
        end else begin
            priv_fault <= cfg_we && !cfg_priv;
        end
    end

    // R6: success and fault are never raised together.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    // R6: every request yields one response in the next cycle.
    a_r6_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid || rsp_fault));

    // R6: no response appears without a request.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_fault));

    // R8: an unprivileged write is flagged in the following cycle.
    a_r8_priv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> priv_fault);

    // R11: the address output is quiet whenever no valid result is shown.
    a_r11_paddr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0));
endmodule

// File: tb/seg_translator_tb.sv
// Scoreboard bench: driver tasks push expected responses, a monitor pops and
// compares them one cycle later.
module seg_translator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [13:0] req_vaddr;
    logic        rsp_valid;
    logic [19:0] rsp_paddr;
    logic        rsp_fault;
    logic        cfg_we, cfg_priv, cfg_valid;
    logic [1:0]  cfg_index;
    logic [19:0] cfg_base;
    logic [11:0] cfg_limit;
    logic        priv_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_translator u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_index(cfg_index),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
        .priv_fault(priv_fault)
    );

    typedef struct packed {
        logic        flt;
        logic [19:0] pa;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_on   = 0;
    bit    pf_exp   = 0;

    // Reference table built from the requirements.
    logic        m_valid [4];
    logic [19:0] m_base  [4];
    logic [11:0] m_limit [4];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(logic [1:0] seg, logic [11:0] off);
        exp_t e;
        e.flt = !(m_valid[seg] && (off <= m_limit[seg]));
        e.pa  = e.flt ? 20'h0 : (m_base[seg] + {8'h0, off});
        return e;
    endfunction

    task automatic clear_inputs();
        req_valid = 0; req_vaddr = '0;
        cfg_we = 0; cfg_priv = 0; cfg_index = '0;
        cfg_base = '0; cfg_limit = '0; cfg_valid = 0;
    endtask

    task automatic xlate(logic [1:0] seg, logic [11:0] off, string tag);
        @(negedge clk);
        clear_inputs();
        req_valid = 1; req_vaddr = {seg, off};   // R2 address layout
        exp_q.push_back(model(seg, off));
        tag_q.push_back(tag);
    endtask

    task automatic cfg(logic [1:0] idx, logic [19:0] b, logic [11:0] l,
                       logic v, logic p);
        @(negedge clk);
        clear_inputs();
        cfg_we = 1; cfg_priv = p; cfg_index = idx;
        cfg_base = b; cfg_limit = l; cfg_valid = v;
        if (p) begin
            m_valid[idx] = v; m_base[idx] = b; m_limit[idx] = l;
        end else begin
            pf_exp = 1;
        end
    endtask

    // R9: write and lookup in one cycle; expectation uses pre-write contents.
    task automatic cfg_and_xlate(logic [1:0] idx, logic [19:0] b, logic [11:0] l,
                                 logic [11:0] off);
        @(negedge clk);
        clear_inputs();
        cfg_we = 1; cfg_priv = 1; cfg_index = idx;
        cfg_base = b; cfg_limit = l; cfg_valid = 1;
        req_valid = 1; req_vaddr = {idx, off};
        exp_q.push_back(model(idx, off));
        tag_q.push_back("R9");
        m_valid[idx] = 1; m_base[idx] = b; m_limit[idx] = l;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_inputs();
        end
    endtask

    // Monitor: compares outputs just after each rising edge.
    initial begin
        wait (mon_on);
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {11'h0, rsp_fault, rsp_valid, rsp_paddr},
                       {11'h0, e.flt, !e.flt, e.pa});
            end else begin
                chk("R6", {30'h0, rsp_fault, rsp_valid}, 32'h0);
            end
            chk("R8", {31'h0, priv_fault}, {31'h0, pf_exp});
            pf_exp = 0;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_base[i] = '0; m_limit[i] = '0;
        end
        clear_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        chk("R1", {12'h0, rsp_valid, rsp_fault, priv_fault, rsp_paddr}, 32'h0);
        @(negedge clk);
        rst_n = 1;
        mon_on = 1;

        // R1/R5: every descriptor starts invalid
        for (int s = 0; s < 4; s++) xlate(2'(s), 12'h000, "R1");

        cfg(2'd0, 20'h10000, 12'hFFF, 1, 1);
        cfg(2'd1, 20'h00400, 12'h0FF, 1, 1);
        cfg(2'd2, 20'hFFF00, 12'h200, 1, 1);
        cfg(2'd3, 20'h05000, 12'hFFF, 0, 1);

        xlate(2'd0, 12'h000, "R3");
        xlate(2'd0, 12'hFFF, "R3");
        xlate(2'd1, 12'h0FF, "R4");   // offset equal to limit: legal
        xlate(2'd1, 12'h100, "R4");   // one above limit: fault
        xlate(2'd2, 12'h150, "R10");  // wraps to 0x00050
        xlate(2'd3, 12'h000, "R5");   // invalid descriptor
        xlate(2'd2, 12'h034, "R2");
        idle(2);

        // R8: unprivileged write ignored and flagged
        cfg(2'd1, 20'h77777, 12'hFFF, 1, 0);
        xlate(2'd1, 12'h100, "R8");
        xlate(2'd1, 12'h010, "R8");

        // R9 then R7: same-cycle write uses old contents, next cycle new ones
        cfg_and_xlate(2'd0, 20'h20000, 12'h0FF, 12'h005);
        xlate(2'd0, 12'h005, "R7");
        xlate(2'd0, 12'h100, "R7");

        // R7/R5: invalidating a descriptor
        cfg(2'd2, 20'hFFF00, 12'h200, 0, 1);
        xlate(2'd2, 12'h000, "R5");

        // R4: zero limit admits only offset zero
        cfg(2'd3, 20'h05000, 12'h000, 1, 1);
        xlate(2'd3, 12'h000, "R4");
        xlate(2'd3, 12'h001, "R4");
        idle(3);

        chk("R6", {31'h0, (exp_q.size() == 0)}, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule